// File: doc/BRIEF.md
# I2C Target Wire Front End

This block is the bus-facing half of an I2C target. It oversamples the SCL and SDA lines with the system clock and passes each line through a synchronizer and a glitch filter. It then finds START, repeated START and STOP conditions, shifts incoming bytes MSB first, and shifts read bytes out. SDA is only ever pulled low, for acknowledge bits and for zero data bits. Otherwise it is released.

The first byte after every START is an address byte. It matches when its upper nibble equals a fixed type code (`4'b1010` by default) and the next three bits equal the `dev_sel` strap pins. On a mismatch the block stays silent until the next START. After a match, a write-direction transaction delivers each received byte to a transaction controller as a one-cycle `rx_valid` strobe. A read-direction transaction sends the byte the controller last presented with `tx_load`.

Neither byte stream has back-pressure, because the bus gives the target no room to stall here (clock stretching is not used):
- `rx_valid` is a single-cycle strobe that the consumer must take in that cycle.
- The controller must present `rx_ack` before the SCL falling edge that opens the acknowledge slot.
- The controller must pulse `tx_load` before the SCL falling edge that closes the preceding acknowledge slot. The strobes `addr_match` (with `rw` = 1) and `master_ack` announce that this window has opened.

Top module: `i2c_tgt_frontend`

## Requirements
- R1: Out of reset, `sda_oe` is 0 and all strobes (`rx_valid`, `addr_match`, `master_ack`, `master_nack`, `start_det`, `stop_det`) are 0.
- R2: A level change on `scl_in` or `sda_in` lasting fewer than FILT_CYCLES system clocks has no effect. A change held for more than FILT_CYCLES clocks is seen.
- R3: `start_det` pulses when filtered SDA falls while filtered SCL is high. `stop_det` pulses when SDA rises while SCL is high. The two never pulse together.
- R4: An address byte with bits 7:4 = `1010` and bits 3:1 = `dev_sel` is acknowledged: SDA is pulled low for the 9th clock, `addr_match` pulses, and `rw` takes bit 0 (0 = write, 1 = read).
- R5: Any other address byte gets no acknowledge, raises no strobe, and every later bit is ignored until the next START.
- R6: In a write transaction each byte is received MSB first. `rx_valid` pulses once with `rx_byte` after the 8th bit. The 9th bit is acknowledged exactly when `rx_ack` is 1 at that point.
- R7: After a data byte that was not acknowledged, further bits are ignored until the next START.
- R8: In a read transaction the loaded byte is sent MSB first. A 0 bit pulls SDA low and a 1 bit releases it.
- R9: In a read, a low SDA in the 9th bit pulses `master_ack` and the next loaded byte follows. A high SDA pulses `master_nack`, and SDA stays released until a START or STOP.
- R10: A START or STOP in any state abandons the partial byte and clears the bit count. After a repeated START the next byte is again an address byte.
- R11: `sda_oe` changes only while the filtered SCL is low, apart from its clearing at START or STOP.
- R12: `rx_valid`, `addr_match`, `master_ack` and `master_nack` each last one cycle, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 = pull SDA low, 0 = release |
| dev_sel | input | 3 | Strap value the address bits 3:1 must equal |
| rx_byte | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle strobe, `rx_byte` is new |
| rx_ack | input | 1 | 1 = acknowledge the byte being received |
| addr_match | output | 1 | One-cycle strobe, address byte accepted |
| rw | output | 1 | Direction of the accepted address, 1 = read |
| tx_byte | input | 8 | Byte to send on the next read slot |
| tx_load | input | 1 | Strobe that captures `tx_byte` |
| master_ack | output | 1 | One-cycle strobe, master acknowledged a read byte |
| master_nack | output | 1 | One-cycle strobe, master refused a read byte |
| start_det | output | 1 | One-cycle strobe on START or repeated START |
| stop_det | output | 1 | One-cycle strobe on STOP |

## Verification
The assertions take a bus that behaves lawfully. The master moves SDA only while SCL is low, except when it signals START or STOP. It never signals either while the target is pulling SDA low. Each SCL phase also outlasts the synchronizer, filter and edge pipeline, so an output change that follows a falling edge lands while SCL is still low. The bench's master model keeps every quarter bit period at eight system clocks, longer than that pipeline. It wires SDA as an AND of its own drive and the target's release. Its only deliberate breaches of the rules are the glitch pulses. Those are kept below the filter length, except for one pulse that is meant to register as a START followed by a STOP.

// File: rtl/i2c_fe_pkg.sv
package i2c_fe_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_CNT_W = 4;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [BIT_CNT_W-1:0] bitcnt_t;
  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_ADDR = 2'd1,
    ENG_RX   = 2'd2,
    ENG_TX   = 2'd3
  } eng_state_e;
  // bit count marks: after the 8th data clock, and inside the acknowledge slot
  localparam bitcnt_t CNT_FULL = 4'd8;
  localparam bitcnt_t CNT_ACK  = 4'd9;
endpackage

// File: rtl/i2c_fe_line_filter.sv
module i2c_fe_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_raw,
  output logic line_clean
);
  localparam int CW = $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          agree_cnt;
  logic                   sync_out;

  assign sync_out = sync_q[SYNC_STAGES-1];

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= line_raw;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_raw};
      end
    end
  endgenerate

  // the clean level follows only after FILT_CYCLES consecutive disagreeing samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_clean <= 1'b1;
      agree_cnt  <= '0;
    end else if (sync_out == line_clean) begin
      agree_cnt <= '0;
    end else if (agree_cnt == CNT_LAST) begin
      line_clean <= sync_out;
      agree_cnt  <= '0;
    end else begin
      agree_cnt <= agree_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_fe_cond_detect.sv
module i2c_fe_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_c,
  input  logic sda_c,
  output logic start_p,
  output logic stop_p,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_c;
      sda_d <= sda_c;
    end
  end

  assign start_p  = scl_c & scl_d & sda_d & ~sda_c;
  assign stop_p   = scl_c & scl_d & ~sda_d & sda_c;
  assign scl_rise = scl_c & ~scl_d;
  assign scl_fall = ~scl_c & scl_d;
endmodule

// File: rtl/i2c_fe_addr_cmp.sv
module i2c_fe_addr_cmp #(
  parameter logic [3:0] TYPE_CODE = 4'b1010,
  parameter int SEL_W = 3
) (
  input  logic [7:0]       addr_byte,
  input  logic [SEL_W-1:0] dev_sel,
  output logic             hit
);
  localparam int SEL_LO = 8 - 4 - SEL_W;
  always_comb begin
    hit = (addr_byte[7:4] == TYPE_CODE) &&
          (addr_byte[3:SEL_LO] == dev_sel);
  end
endmodule

// File: rtl/i2c_fe_byte_engine.sv
module i2c_fe_byte_engine
  import i2c_fe_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_p,
  input  logic   stop_p,
  input  logic   scl_rise,
  input  logic   scl_fall,
  input  logic   sda_c,
  input  logic   addr_hit,
  input  logic   rx_ack,
  input  byte_t  tx_byte,
  input  logic   tx_load,
  output byte_t  shift_q,
  output logic   sda_oe,
  output byte_t  rx_byte,
  output logic   rx_valid,
  output logic   addr_match,
  output logic   rw,
  output logic   master_ack,
  output logic   master_nack
);
  eng_state_e st;
  bitcnt_t    bcnt;
  byte_t      tx_buf;
  byte_t      tx_next;
  logic       acked;

  assign tx_next = tx_load ? tx_byte : tx_buf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ENG_IDLE;
      bcnt        <= '0;
      shift_q     <= '0;
      tx_buf      <= '1;
      acked       <= 1'b0;
      sda_oe      <= 1'b0;
      rx_byte     <= '0;
      rx_valid    <= 1'b0;
      addr_match  <= 1'b0;
      rw          <= 1'b0;
      master_ack  <= 1'b0;
      master_nack <= 1'b0;
    end else begin
      rx_valid    <= 1'b0;
      addr_match  <= 1'b0;
      master_ack  <= 1'b0;
      master_nack <= 1'b0;
      if (tx_load) tx_buf <= tx_byte;

      if (start_p) begin
        st     <= ENG_ADDR;
        bcnt   <= '0;
        sda_oe <= 1'b0;
      end else if (stop_p) begin
        st     <= ENG_IDLE;
        bcnt   <= '0;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ENG_IDLE: ;
          ENG_ADDR, ENG_RX: begin
            if (scl_rise && bcnt < CNT_FULL) begin
              shift_q <= {shift_q[6:0], sda_c};
              bcnt    <= bcnt + 4'd1;
            end else if (scl_fall && bcnt == CNT_FULL) begin
              bcnt <= CNT_ACK;
              if (st == ENG_ADDR) begin
                if (addr_hit) begin
                  sda_oe     <= 1'b1;
                  addr_match <= 1'b1;
                  rw         <= shift_q[0];
                end else begin
                  st   <= ENG_IDLE;
                  bcnt <= '0;
                end
              end else begin
                rx_valid <= 1'b1;
                rx_byte  <= shift_q;
                sda_oe   <= rx_ack;
                acked    <= rx_ack;
              end
            end else if (scl_fall && bcnt == CNT_ACK) begin
              sda_oe <= 1'b0;
              bcnt   <= '0;
              if (st == ENG_ADDR) begin
                if (rw) begin
                  st      <= ENG_TX;
                  shift_q <= tx_next;
                  sda_oe  <= ~tx_next[7];
                end else begin
                  st <= ENG_RX;
                end
              end else if (!acked) begin
                st <= ENG_IDLE;
              end
            end
          end
          ENG_TX: begin
            if (scl_rise) begin
              if (bcnt < CNT_FULL) begin
                bcnt <= bcnt + 4'd1;
              end else if (bcnt == CNT_ACK) begin
                if (!sda_c) begin
                  master_ack <= 1'b1;
                  acked      <= 1'b1;
                end else begin
                  master_nack <= 1'b1;
                  acked       <= 1'b0;
                end
              end
            end else if (scl_fall) begin
              if (bcnt >= 4'd1 && bcnt < CNT_FULL) begin
                shift_q <= {shift_q[6:0], 1'b0};
                sda_oe  <= ~shift_q[6];
              end else if (bcnt == CNT_FULL) begin
                sda_oe <= 1'b0;
                bcnt   <= CNT_ACK;
              end else if (bcnt == CNT_ACK) begin
                bcnt <= '0;
                if (acked) begin
                  shift_q <= tx_next;
                  sda_oe  <= ~tx_next[7];
                end else begin
                  st <= ENG_IDLE;
                end
              end
            end
          end
          default: st <= ENG_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_tgt_frontend.sv
module i2c_tgt_frontend #(
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_CYCLES = 3,
  parameter logic [3:0] TYPE_CODE   = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic [2:0] dev_sel,
  output logic [7:0] rx_byte,
  output logic       rx_valid,
  input  logic       rx_ack,
  output logic       addr_match,
  output logic       rw,
  input  logic [7:0] tx_byte,
  input  logic       tx_load,
  output logic       master_ack,
  output logic       master_nack,
  output logic       start_det,
  output logic       stop_det
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_lines;
  logic [N_LINES-1:0] clean_lines;
  logic scl_clean, sda_clean;
  logic scl_rise, scl_fall;
  logic addr_hit;
  logic [7:0] shift_q;

  assign raw_lines = {sda_in, scl_in};
  assign scl_clean = clean_lines[0];
  assign sda_clean = clean_lines[1];

  generate
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
      i2c_fe_line_filter #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_CYCLES(FILT_CYCLES)
      ) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_raw  (raw_lines[i]),
        .line_clean(clean_lines[i])
      );
    end
  endgenerate

  i2c_fe_cond_detect u_cond (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_c   (scl_clean),
    .sda_c   (sda_clean),
    .start_p (start_det),
    .stop_p  (stop_det),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall)
  );

  i2c_fe_addr_cmp #(
    .TYPE_CODE(TYPE_CODE),
    .SEL_W    (3)
  ) u_cmp (
    .addr_byte(shift_q),
    .dev_sel  (dev_sel),
    .hit      (addr_hit)
  );

  i2c_fe_byte_engine u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_p    (start_det),
    .stop_p     (stop_det),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .sda_c      (sda_clean),
    .addr_hit   (addr_hit),
    .rx_ack     (rx_ack),
    .tx_byte    (tx_byte),
    .tx_load    (tx_load),
    .shift_q    (shift_q),
    .sda_oe     (sda_oe),
    .rx_byte    (rx_byte),
    .rx_valid   (rx_valid),
    .addr_match (addr_match),
    .rw         (rw),
    .master_ack (master_ack),
    .master_nack(master_nack)
  );
endmodule

// File: rtl/i2c_tgt_frontend_chk.sv
module i2c_tgt_frontend_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_clean,
  input logic sda_oe,
  input logic rx_valid,
  input logic addr_match,
  input logic master_ack,
  input logic master_nack,
  input logic start_det,
  input logic stop_det
);
  // R11
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!scl_clean || start_det || stop_det || !sda_oe));

  // R3
  cond_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_det && stop_det));

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_valid, addr_match, master_ack, master_nack}));

  // R12
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R4
  match_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_match |-> sda_oe);

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R9
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    master_nack |-> !sda_oe);
endmodule

bind i2c_tgt_frontend i2c_tgt_frontend_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_clean  (scl_clean),
  .sda_oe     (sda_oe),
  .rx_valid   (rx_valid),
  .addr_match (addr_match),
  .master_ack (master_ack),
  .master_nack(master_nack),
  .start_det  (start_det),
  .stop_det   (stop_det)
);

// File: tb/i2c_tgt_frontend_test.sv
module i2c_tgt_frontend_test;
  localparam int Q = 8;
  localparam int FILT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic [2:0] dev_sel = 3'b101;
  logic rx_ack = 1'b1;
  logic [7:0] tx_byte = 8'hFF;
  logic tx_load = 1'b0;
  logic sda_oe, rx_valid, addr_match, rw, master_ack, master_nack, start_det, stop_det;
  logic [7:0] rx_byte;
  logic sda_bus;

  assign sda_bus = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_tgt_frontend #(.FILT_CYCLES(FILT)) uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus), .sda_oe(sda_oe),
    .dev_sel(dev_sel), .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ack(rx_ack),
    .addr_match(addr_match), .rw(rw), .tx_byte(tx_byte), .tx_load(tx_load),
    .master_ack(master_ack), .master_nack(master_nack),
    .start_det(start_det), .stop_det(stop_det));

  int n_chk = 0, n_err = 0;
  int n_rx = 0, n_match = 0, n_mack = 0, n_mnack = 0, n_start = 0, n_stop = 0;
  logic [7:0] rx_log [0:63];
  bit rd_mode = 1'b0;
  int rd_idx = 0;
  bit done = 1'b0;

  function automatic logic [7:0] rd_val(input int idx);
    return rd_mode ? 8'((idx * 37 + 5) % 256) : 8'hFF;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // output monitor and transaction-controller model
  initial begin
    forever begin
      @(negedge clk);
      tx_load = 1'b0;
      if (rx_valid) begin
        if (n_rx < 64) rx_log[n_rx] = rx_byte;
        n_rx++;
      end
      if (addr_match) n_match++;
      if (master_ack) n_mack++;
      if (master_nack) n_mnack++;
      if (start_det) n_start++;
      if (stop_det) n_stop++;
      if ((addr_match && rw) || master_ack) begin
        tx_byte = rd_val(rd_idx);
        tx_load = 1'b1;
        rd_idx++;
      end
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    wq(Q); sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0;
  endtask

  task automatic bus_stop;
    wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  // one bit slot with optional short pulses: SCL pulse in low phase, SDA pulse in high phase
  task automatic bit_slot(input logic b, input int sda_gl, input int scl_gl, output logic s);
    wq(Q);
    sda_m = b;
    if (scl_gl > 0) begin
      wq(2); scl = 1'b1; wq(scl_gl); scl = 1'b0; wq(Q - 2 - scl_gl);
    end else wq(Q);
    scl = 1'b1;
    if (sda_gl > 0) begin
      wq(2); sda_m = ~b; wq(sda_gl); sda_m = b; wq(Q - 2 - sda_gl);
    end else wq(Q);
    s = sda_bus;
    wq(Q);
    scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_slot(v[i], 0, 0, s);
    bit_slot(1'b1, 0, 0, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_slot(1'b1, 0, 0, s);
      v[i] = s;
    end
    bit_slot(~give_ack, 0, 0, s);
  endtask

  logic ack;
  logic s_dummy;
  logic [7:0] rv;
  int base_rx, base_m, base_s, base_p;

  initial begin
    wq(5);
    // R1: reset state
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 strobes", {rx_valid, addr_match, master_ack, master_nack, start_det, stop_det}, 0);
    rst_n = 1'b1;
    wq(4);
    chk("R1 after release", {sda_oe, rx_valid, addr_match, start_det, stop_det}, 0);

    // R4/R5: sweep of every address byte
    base_rx = n_rx; base_m = n_match;
    for (int a = 0; a < 256; a++) begin
      logic [7:0] ab;
      ab = 8'(a);
      bus_start();
      send_byte(ab, ack);
      if (ab[7:4] == 4'hA && ab[3:1] == dev_sel) begin
        chk($sformatf("R4 ack for %02h", ab), ack, 1);
        chk($sformatf("R4 rw for %02h", ab), rw, ab[0]);
      end else begin
        chk($sformatf("R5 no ack for %02h", ab), ack, 0);
      end
      bus_stop();
    end
    chk("R4 match count", n_match - base_m, 2);
    chk("R5 no rx strobes in sweep", n_rx - base_rx, 0);
    chk("R3 start count", n_start, 256);
    chk("R3 stop count", n_stop, 256);

    // R6/R7: write stream, then a refused byte
    base_rx = n_rx;
    rx_ack = 1'b1;
    bus_start();
    send_byte(8'hAA, ack);
    chk("R6 addr ack", ack, 1);
    begin
      logic [7:0] pat [0:4];
      pat = '{8'h00, 8'hFF, 8'h5A, 8'hC3, 8'h81};
      for (int k = 0; k < 5; k++) begin
        send_byte(pat[k], ack);
        chk("R6 data ack", ack, 1);
        chk("R6 rx_byte", rx_log[base_rx + k], pat[k]);
      end
    end
    rx_ack = 1'b0;
    send_byte(8'h3C, ack);
    chk("R6 nack when rx_ack low", ack, 0);
    chk("R6 refused byte still delivered", rx_log[base_rx + 5], 8'h3C);
    rx_ack = 1'b1;
    send_byte(8'h77, ack);
    chk("R7 ignored after nack", ack, 0);
    chk("R7 no rx after nack", n_rx - base_rx, 6);
    bus_stop();

    // R8/R9: random-read style sequence
    rd_mode = 1'b1; rd_idx = 0;
    base_rx = n_rx; base_m = n_mack;
    bus_start();
    send_byte(8'hAA, ack);
    send_byte(8'h12, ack);
    chk("R6 offset byte", rx_log[base_rx], 8'h12);
    bus_start();
    send_byte(8'hAB, ack);
    chk("R10 repeated start read addr ack", ack, 1);
    chk("R4 rw read", rw, 1);
    for (int k = 0; k < 4; k++) begin
      recv_byte(k < 3, rv);
      chk($sformatf("R8 read byte %0d", k), rv, rd_val(k));
    end
    chk("R9 master_ack count", n_mack - base_m, 3);
    chk("R9 master_nack count", n_mnack, 1);
    recv_byte(1'b0, rv);
    chk("R9 released after nack", rv, 8'hFF);
    bus_stop();
    rd_mode = 1'b0;

    // R10: abort mid-byte by repeated start, and by stop
    bus_start();
    for (int i = 7; i >= 4; i--) bit_slot(1'(8'hAA >> i), 0, 0, s_dummy);
    bus_start();
    send_byte(8'hAA, ack);
    chk("R10 address after mid-byte restart", ack, 1);
    for (int i = 0; i < 3; i++) bit_slot(1'b0, 0, 0, s_dummy);
    bus_stop();
    base_rx = n_rx;
    wq(Q); scl = 1'b0;
    send_byte(8'hAA, ack);
    chk("R10 no response after stop", ack, 0);
    chk("R10 no rx after stop", n_rx - base_rx, 0);
    bus_stop();

    // R2: short pulses rejected, long pulse seen
    base_rx = n_rx; base_s = n_start; base_p = n_stop;
    bus_start();
    send_byte(8'hAA, ack);
    begin
      logic [7:0] gv;
      gv = 8'h96;
      for (int i = 7; i >= 0; i--)
        bit_slot(gv[i], (i == 3) ? FILT - 1 : 0, (i == 5) ? FILT - 1 : 0, s_dummy);
      bit_slot(1'b1, 0, 0, s_dummy);
      chk("R2 byte intact despite pulses", rx_log[base_rx], gv);
      chk("R2 no extra conditions", (n_start - base_s) * 16 + (n_stop - base_p), 16);
    end
    bit_slot(1'b1, FILT + 1, 0, s_dummy);
    chk("R2 long pulse start", n_start - base_s, 2);
    chk("R3 long pulse stop", n_stop - base_p, 1);
    bus_stop();

    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (190000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule